// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This block gives every hart of a small multi-hart cluster two interrupt sources: a software interrupt that any bus master can raise or clear by writing a per-hart word, and a timer interrupt driven by comparing one shared 64-bit time counter against a per-hart 64-bit compare value. The counter is shared, advances once per timebase tick, and wraps across all 64 bits.

Software arms a one-shot timer event by reading the counter, adding a delta and writing the sum into its hart's compare register. The line stays asserted until the compare register is moved above the counter. The 64-bit values are reachable as two 32-bit halves. Counter reads are live, so a 32-bit master reads high, low, high and retries on a mismatch. All registers sit on a simple register bus with byte strobes. The bus completes each access one cycle after the request.

Top module: `core_timer_unit`

## Requirements
- R1: After reset the counter is 0, every software-interrupt bit is 0, every compare register is all-ones, no interrupt line is high and `ready_o` is low.
- R2: The software-interrupt word of hart n sits at byte offset 4*n. Its bit 0 is the hart's software-interrupt line and reads back. Bits 31:1 read as zero and ignore writes.
- R3: The compare register of hart n sits at 0x4000 + 8*n, with its low half at that offset and its high half 4 bytes above. Both halves read back what was written.
- R4: The counter's low half reads at 0xBFF8 and its high half at 0xBFFC. Each read returns the live value held at the request edge.
- R5: The counter advances by exactly one on each clock edge where `tick_i` is high, and holds otherwise. The carry runs from the low into the high half, and all-ones wraps to zero.
- R6: The counter is writable through its two halves. A write on the same edge as a tick takes priority, and the written value is loaded without an increment.
- R7: `timer_irq_o[n]` is high exactly while the counter is at least compare n, as an unsigned 64-bit comparison. With compare fixed and the counter only counting up, the line stays high. Rewriting compare above the counter drops it.
- R8: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register. This includes words just beyond the last hart in both per-hart regions.
- R9: `ready_o` is high in the cycle after each cycle with `req_i` high, and low otherwise. `rdata_o` carries the read value with it, and zero for writes.
- R10: Write strobe bit b (`be_i[b]`) enables data byte b. Bytes whose strobe is low keep their old value in compare and counter halves. A software word changes only when `be_i[0]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick enable, one counter step per high cycle |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address within the block |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte write strobes |
| ready_o | output | 1 | Access complete, one cycle after request |
| rdata_o | output | 32 | Read data, valid with ready_o |
| soft_irq_o | output | NUM_HARTS | Per-hart software interrupt |
| timer_irq_o | output | NUM_HARTS | Per-hart timer interrupt |

## Verification
The assertions assume that the bus presents word-aligned byte addresses, with the low two bits ignored, and that a master holds `req_i` for a single cycle per access. They also assume that nobody presets the counter to all-ones and then lets it tick in a way the timer-hold property would misread. The stimulus issues one access at a time with aligned offsets. It keeps `tick_i` low around counter reads so that the expected live value is known exactly. It raises the tick together with a counter write only in the one case that tests write priority.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  typedef enum logic [1:0] {RG_NONE, RG_SOFT, RG_CMP, RG_TIME} region_e;

  localparam logic [31:0] SOFT_BASE = 32'h0000_0000;
  localparam logic [31:0] CMP_BASE  = 32'h0000_4000;
  localparam logic [31:0] TIME_BASE = 32'h0000_BFF8;

  function automatic logic [31:0] merge_be(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/ctu_decode.sv
module ctu_decode
  import ctu_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  hart_o,
  output logic              hi_o
);
  localparam logic [31:0] SOFT_END = SOFT_BASE + 32'(4 * NUM_HARTS);
  localparam logic [31:0] CMP_END  = CMP_BASE + 32'(8 * NUM_HARTS);

  logic [31:0] a32;
  assign a32 = 32'(addr_i);

  always_comb begin
    region_o = RG_NONE;
    hart_o   = '0;
    hi_o     = a32[2];
    if (a32 < SOFT_END) begin
      region_o = RG_SOFT;
      hart_o   = IDX_W'((a32 - SOFT_BASE) >> 2);
    end else if (a32 >= CMP_BASE && a32 < CMP_END) begin
      region_o = RG_CMP;
      hart_o   = IDX_W'((a32 - CMP_BASE) >> 3);
    end else if ((a32 & ~32'h7) == TIME_BASE) begin
      region_o = RG_TIME;
    end
  end
endmodule

// File: rtl/ctu_counter.sv
module ctu_counter
  import ctu_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic             hi_i,
  input  logic [31:0]      wdata_i,
  input  logic [3:0]       be_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_wr;

  always_comb begin
    cnt_wr = cnt_q;
    if (hi_i) cnt_wr[63:32] = merge_be(cnt_q[63:32], wdata_i, be_i);
    else      cnt_wr[31:0]  = merge_be(cnt_q[31:0], wdata_i, be_i);
  end

  // bus write wins over a coincident tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= cnt_wr;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_i |=> cnt_o == $past(cnt_o) + 64'd1);
  // R5
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_i |=> $stable(cnt_o));
  // R6
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !hi_i && be_i == 4'hF |=> cnt_o[31:0] == $past(wdata_i));
endmodule

// File: rtl/ctu_hart.sv
module ctu_hart
  import ctu_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_wr_i,
  input  logic             cmp_wr_i,
  input  logic             hi_i,
  input  logic [31:0]      wdata_i,
  input  logic [3:0]       be_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             soft_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             timer_o
);
  logic             soft_q;
  logic [CNT_W-1:0] cmp_q, cmp_nxt;

  always_comb begin
    cmp_nxt = cmp_q;
    if (hi_i) cmp_nxt[63:32] = merge_be(cmp_q[63:32], wdata_i, be_i);
    else      cmp_nxt[31:0]  = merge_be(cmp_q[31:0], wdata_i, be_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_q <= 1'b0;
      cmp_q  <= '1;
    end else begin
      if (soft_wr_i && be_i[0]) soft_q <= wdata_i[0];
      if (cmp_wr_i)             cmp_q  <= cmp_nxt;
    end
  end

  assign soft_o  = soft_q;
  assign cmp_o   = cmp_q;
  assign timer_o = (cnt_i >= cmp_q);

  // R2
  soft_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_wr_i && be_i[0] |=> soft_o == $past(wdata_i[0]));
  // R10
  soft_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(soft_wr_i && be_i[0]) |=> $stable(soft_o));
  // R3
  cmp_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_wr_i |=> $stable(cmp_o));
endmodule

// File: rtl/core_timer_unit.sv
module core_timer_unit
  import ctu_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  input  logic [3:0]           be_i,
  output logic                 ready_o,
  output logic [31:0]          rdata_o,
  output logic [NUM_HARTS-1:0] soft_irq_o,
  output logic [NUM_HARTS-1:0] timer_irq_o
);
  localparam int CNT_W = 64;
  localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  region_e          region;
  logic [IDX_W-1:0] hart;
  logic             hi;
  logic             wr, cnt_wr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp_all [NUM_HARTS];
  logic [NUM_HARTS-1:0] soft_wr, cmp_wr;
  logic [31:0]      rd_mux;
  logic             ready_q;
  logic [31:0]      rdata_q;

  ctu_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_decode (
    .addr_i  (addr_i),
    .region_o(region),
    .hart_o  (hart),
    .hi_o    (hi)
  );

  assign wr     = req_i && we_i;
  assign cnt_wr = wr && (region == RG_TIME);

  ctu_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .wr_i   (cnt_wr),
    .hi_i   (hi),
    .wdata_i(wdata_i),
    .be_i   (be_i),
    .cnt_o  (cnt)
  );

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
    assign soft_wr[i] = wr && (region == RG_SOFT) && (hart == IDX_W'(i));
    assign cmp_wr[i]  = wr && (region == RG_CMP)  && (hart == IDX_W'(i));

    ctu_hart #(.CNT_W(CNT_W)) u_hart (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .soft_wr_i(soft_wr[i]),
      .cmp_wr_i (cmp_wr[i]),
      .hi_i     (hi),
      .wdata_i  (wdata_i),
      .be_i     (be_i),
      .cnt_i    (cnt),
      .soft_o   (soft_irq_o[i]),
      .cmp_o    (cmp_all[i]),
      .timer_o  (timer_irq_o[i])
    );

    // R7: fixed compare and a counting-up counter keep the line high
    timer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timer_irq_o[i] && !cmp_wr[i] && !cnt_wr && cnt != '1 |=> timer_irq_o[i]);
  end

  always_comb begin
    unique case (region)
      RG_SOFT: rd_mux = {31'b0, soft_irq_o[hart]};
      RG_CMP:  rd_mux = hi ? cmp_all[hart][63:32] : cmp_all[hart][31:0];
      RG_TIME: rd_mux = hi ? cnt[63:32] : cnt[31:0];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= req_i;
      rdata_q <= (req_i && !we_i) ? rd_mux : '0;
    end
  end

  assign ready_o = ready_q;
  assign rdata_o = rdata_q;

  // R9
  ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);
  // R9
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);
  // R8
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && region == RG_NONE |=> rdata_o == 32'd0);
  // R8
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && region == RG_NONE |=> $stable(soft_irq_o));
endmodule

// File: tb/sim_core_timer_unit.sv
`timescale 1ns/1ps
module sim_core_timer_unit;
  localparam int N = 4;

  logic clk = 0, rst_ni = 0, tick_i = 0, req_i = 0, we_i = 0;
  logic [15:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  be_i = '0;
  logic        ready_o;
  logic [31:0] rdata_o;
  logic [N-1:0] soft_irq_o, timer_irq_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  core_timer_unit #(.NUM_HARTS(N), .ADDR_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i), .ready_o(ready_o),
    .rdata_o(rdata_o), .soft_irq_o(soft_irq_o), .timer_irq_o(timer_irq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected response on each completed access
  always @(negedge clk) begin
    if (rst_ni && ready_o) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected ready", 64'(rdata_o), 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata_o == e, t, 64'(rdata_o), 64'(e));
      end
    end
  end

  task automatic bus(input logic [15:0] a, input bit w, input logic [31:0] d,
                     input logic [3:0] be, input bit tk, input logic [31:0] exp,
                     input string tag);
    @(negedge clk);
    req_i = 1; we_i = w; addr_i = a; wdata_i = d; be_i = be; tick_i = tk;
    exp_q.push_back(w ? 32'd0 : exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_i = 0; we_i = 0; tick_i = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    bus(a, 1, d, be, 0, 0, "R9 write response");
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    bus(a, 0, 0, 0, 0, exp, tag);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_i = 1;
    end
    @(negedge clk);
    tick_i = 0;
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(soft_irq_o == 0, "R1 soft", 64'(soft_irq_o), 0);
    check(timer_irq_o == 0, "R1 timer", 64'(timer_irq_o), 0);
    check(ready_o == 0, "R1 ready", 64'(ready_o), 0);
    rst_ni = 1;
    rd(16'hBFF8, 0, "R1 cnt lo");
    rd(16'hBFFC, 0, "R1 cnt hi");
    rd(16'h4000, 32'hFFFF_FFFF, "R1 cmp0 lo");
    rd(16'h4004, 32'hFFFF_FFFF, "R3 cmp0 hi");

    // R2 software interrupt words
    wr(16'h0008, 32'hFFFF_FFFF, 4'hF);
    check(soft_irq_o == 4'b0100, "R2 soft hart2", 64'(soft_irq_o), 64'h4);
    rd(16'h0008, 32'd1, "R2 upper bits zero");
    wr(16'h0004, 32'd1, 4'hF);
    wr(16'h0004, 32'd0, 4'b1110);
    check(soft_irq_o == 4'b0110, "R10 strobe byte0 off", 64'(soft_irq_o), 64'h6);
    wr(16'h0008, 32'hFFFF_FFFE, 4'hF);
    wr(16'h0004, 32'd0, 4'hF);
    check(soft_irq_o == 4'b0000, "R2 soft cleared", 64'(soft_irq_o), 0);

    // R3 / R10 compare halves with strobes
    wr(16'h4018, 32'h0000_0012, 4'b0001);
    rd(16'h4018, 32'hFFFF_FF12, "R10 cmp3 lo byte0");
    wr(16'h401C, 32'hAABB_CCDD, 4'b1100);
    rd(16'h401C, 32'hAABB_FFFF, "R10 cmp3 hi bytes");

    // R4 / R5 counting
    ticks(5);
    rd(16'hBFF8, 32'd5, "R5 count 5");
    rd(16'hBFFC, 32'd0, "R4 cnt hi");
    @(negedge clk);
    check(ready_o == 0, "R9 idle", 64'(ready_o), 0);

    // R6 write beats coincident tick
    bus(16'hBFF8, 1, 32'd100, 4'hF, 1, 0, "R9 write response");
    rd(16'hBFF8, 32'd100, "R6 write priority");

    // R5 carry and wrap
    wr(16'hBFF8, 32'hFFFF_FFFF, 4'hF);
    ticks(1);
    rd(16'hBFFC, 32'd1, "R5 carry hi");
    rd(16'hBFF8, 32'd0, "R5 carry lo");
    wr(16'hBFFC, 32'hFFFF_FFFF, 4'hF);
    wr(16'hBFF8, 32'hFFFF_FFFF, 4'hF);
    ticks(1);
    rd(16'hBFF8, 32'd0, "R5 wrap lo");
    rd(16'hBFFC, 32'd0, "R5 wrap hi");

    // R7 timer compare on hart1
    wr(16'h400C, 32'd0, 4'hF);
    wr(16'h4008, 32'd10, 4'hF);
    check(timer_irq_o == 0, "R7 below compare", 64'(timer_irq_o), 0);
    ticks(9);
    check(timer_irq_o == 0, "R7 at 9", 64'(timer_irq_o), 0);
    ticks(1);
    check(timer_irq_o == 4'b0010, "R7 reach 10", 64'(timer_irq_o), 64'h2);
    ticks(3);
    check(timer_irq_o == 4'b0010, "R7 holds", 64'(timer_irq_o), 64'h2);
    wr(16'h4014, 32'd0, 4'hF);
    wr(16'h4010, 32'd0, 4'hF);
    check(timer_irq_o == 4'b0110, "R7 hart2 compare zero", 64'(timer_irq_o), 64'h6);
    wr(16'h4008, 32'd100, 4'hF);
    check(timer_irq_o == 4'b0100, "R7 rearm clears", 64'(timer_irq_o), 64'h4);

    // R8 unmapped
    wr(16'h8000, 32'hFFFF_FFFF, 4'hF);
    wr(16'h0010, 32'd1, 4'hF);
    wr(16'h4020, 32'd0, 4'hF);
    check(soft_irq_o == 0, "R8 no soft change", 64'(soft_irq_o), 0);
    check(timer_irq_o == 4'b0100, "R8 no timer change", 64'(timer_irq_o), 64'h4);
    rd(16'h8000, 32'd0, "R8 read 0x8000");
    rd(16'h0010, 32'd0, "R8 read past soft");
    rd(16'h4020, 32'd0, "R8 read past cmp");
    rd(16'h4008, 32'd100, "R3 cmp1 lo");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 responses drained", 64'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule